// File: doc/BRIEF.md
# Multi-mode timer counter core

This block is a 16-bit timer. It takes ticks from one of two clock-enable inputs and passes them through a power-of-two prescaler. It then advances a counter in one of four modes: stop, up, continuous or up/down. The period for up and up/down counting comes from the compare value of channel 0. A programmable set of compare channels, from two to seven, each raises a flag when the counter moves past its value. An overflow flag marks the end of each counting cycle.

Software reaches the block through a small synchronous word port. Every access is answered one cycle later with read data and an error bit. Input capture and interrupt arbitration sit in neighbouring blocks, which watch the flag outputs.

Top module: `tmr_core`

## Requirements
- R1: After reset the control word, the counter, all channel registers and all flags read 0.
- R2: Control bits [4:3] select the mode: 00 stop, 01 up, 10 continuous, 11 up/down. In stop mode the counter holds whatever value it has.
- R3: Control bit 0 picks the tick source (0 = tick_a, 1 = tick_b). Ticks on the other input leave the counter unchanged.
- R4: Control bits [2:1] set the prescale to 1, 2, 4 or 8 source ticks per count. After a clear, 80 source ticks give counts of 80, 40, 20 or 10.
- R5: Writing control with bit 5 set forces the counter and the prescaler to 0. Bit 5 always reads back as 0.
- R6: In up mode the counter climbs to the channel 0 value. The next counting tick returns it to 0 and sets the channel 0 flag and the overflow flag (control bit 6, port ovf_flag).
- R7: With a channel 0 value of 0, up mode and up/down mode hold the counter, while continuous mode keeps counting.
- R8: In continuous mode a counting tick at 0xFFFF gives 0 and sets the overflow flag.
- R9: In up/down mode the counter climbs to the channel 0 value, then descends. The tick that brings it to 0 sets the overflow flag, and counting turns upward again.
- R10: A channel flag (channel control bit 0, port cmp_flag) sets on a counting tick taken while the counter equals that channel's value. The same tick copies the channel's ch_in level into channel control bit 1.
- R11: Word byte offsets: control 0x00, counter 0x10, channel i control 0x02+2i, channel i value 0x12+2i. Odd offsets and offsets of channels that are not present give bus_err=1 with read data 0, and their writes change nothing.
- R12: Writing the counter loads it directly. Writing control or a channel control stores the given flag bit, so writing 0 clears the flag.
- R13: A control write that changes the divide field restarts the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| bus_err | output | 1 | Address error, one cycle after the request |
| tick_a | input | 1 | First tick source (clock enable) |
| tick_b | input | 1 | Second tick source (clock enable) |
| ch_in | input | NCH | Per-channel input level |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | NCH | Per-channel compare flags |

## Verification
A tick driven in one cycle changes the counter and the flags at the next rising edge. These results can be seen on ovf_flag and cmp_flag half a cycle later. A read sent in a cycle returns its data and error bit on the next edge. The bench therefore compares flags, read data and error against its model at each falling edge, one edge after the stimulus. Directed reads follow the last tick by one cycle, so they always see the settled count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CW    = 16;
  localparam int PRE_W = 3;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } mode_e;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          down;
    logic          ovf;
  } step_t;

  // last prescaler state before a count step: 0,1,3,7
  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] d);
    return PRE_W'((4'd1 << d) - 4'd1);
  endfunction

  function automatic logic may_run(input mode_e m, input logic [CW-1:0] per);
    return (m != MODE_STOP) && !((m == MODE_UP || m == MODE_UPDN) && per == '0);
  endfunction

  function automatic step_t next_count(input mode_e m, input logic [CW-1:0] c,
                                       input logic [CW-1:0] per, input logic dn);
    step_t r;
    r.cnt  = c;
    r.down = dn;
    r.ovf  = 1'b0;
    case (m)
      MODE_UP: begin
        if (c >= per) begin
          r.cnt = '0;
          r.ovf = 1'b1;
        end else r.cnt = c + 1'b1;
      end
      MODE_CONT: begin
        r.cnt = c + 1'b1;
        r.ovf = (c == {CW{1'b1}});
      end
      MODE_UPDN: begin
        if (!dn && c < per) r.cnt = c + 1'b1;
        else if (dn && c == '0) begin
          r.cnt  = CW'(1);
          r.down = 1'b0;
        end else begin
          r.cnt  = c - 1'b1;
          r.ovf  = (c == CW'(1));
          r.down = (c != CW'(1));
        end
      end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale import tmr_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] div,
  input  logic       restart,
  output logic       step
);
  logic [PRE_W-1:0] pre_q;

  assign step = tick && !restart && (pre_q == div_last(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (tick)    pre_q <= step ? '0 : pre_q + 1'b1;
  end

  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pre_q == '0));
  assert_pre_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count import tmr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  mode_e         mode,
  input  logic [CW-1:0] period,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          adv,
  output logic          ovf_set
);
  step_t nxt;
  logic  down_q;

  always_comb begin
    nxt     = next_count(mode, cnt, period, down_q);
    adv     = step && may_run(mode, period) && !load && !clr;
    ovf_set = adv && nxt.ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
    end else if (adv) begin
      cnt    <= nxt.cnt;
      down_q <= nxt.down;
    end
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  assert_hold_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP && !load && !clr) |=> $stable(cnt));
  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_UP || mode == MODE_UPDN) && period == '0 && !load && !clr) |=> $stable(cnt));
  assert_up_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && mode == MODE_UP) |=> (cnt == '0));
  assert_cont_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && mode == MODE_CONT) |-> (cnt == {CW{1'b1}}));
  assert_updn_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && mode == MODE_UPDN) |-> (cnt == CW'(1)));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          adv,
  input  logic          val_we,
  input  logic          ctl_we,
  input  logic [CW-1:0] wdata,
  input  logic          in_lvl,
  output logic [CW-1:0] val,
  output logic          flag,
  output logic          sync,
  output logic          hit
);
  assign hit = adv && (cnt == val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val  <= '0;
      flag <= 1'b0;
      sync <= 1'b0;
    end else begin
      if (val_we) val <= wdata;
      flag <= (ctl_we ? wdata[0] : flag) | hit;
      if (hit) sync <= in_lvl;
    end
  end

  assert_hit_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  assert_hit_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (sync == $past(in_lvl)));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_en,
  input  logic           bus_wr,
  input  logic [4:0]     bus_addr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  output logic           bus_err,
  input  logic           tick_a,
  input  logic           tick_b,
  input  logic [NCH-1:0] ch_in,
  output logic           ovf_flag,
  output logic [NCH-1:0] cmp_flag
);
  import tmr_pkg::*;

  localparam logic [3:0] W_CTL = 4'd0;
  localparam logic [3:0] W_CNT = 4'd8;
  localparam logic [3:0] NCH_W = 4'(NCH);

  logic [3:0]    word;
  logic          in_chctl, in_chval, legal, wr_ok, rd_ok;
  logic          ctl_wr, cnt_wr, clr, restart;
  logic          src_q, ovf_q;
  logic [1:0]    div_q;
  mode_e         mode_q;
  logic          tick_sel, step, adv, ovf_set;
  logic [CW-1:0] cnt_q, rd_val;
  logic [CW-1:0] ch_val [NCH];
  logic [NCH-1:0] ch_flag, ch_sync, ch_hit;

  // address decode
  assign word     = bus_addr[4:1];
  assign in_chctl = (word >= 4'd1) && (word <= NCH_W);
  assign in_chval = (word >= 4'd9) && ((word - 4'd8) <= NCH_W);
  assign legal    = bus_en && !bus_addr[0] &&
                    (word == W_CTL || word == W_CNT || in_chctl || in_chval);
  assign wr_ok    = legal && bus_wr;
  assign rd_ok    = legal && !bus_wr;
  assign ctl_wr   = wr_ok && word == W_CTL;
  assign cnt_wr   = wr_ok && word == W_CNT;
  assign clr      = ctl_wr && bus_wdata[5];
  assign restart  = clr || (ctl_wr && bus_wdata[2:1] != div_q);
  assign tick_sel = src_q ? tick_b : tick_a;

  tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel), .div(div_q),
    .restart(restart), .step(step)
  );

  tmr_count u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .mode(mode_q), .period(ch_val[0]),
    .load(cnt_wr), .load_val(bus_wdata), .clr(clr),
    .cnt(cnt_q), .adv(adv), .ovf_set(ovf_set)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .adv(adv),
      .val_we(wr_ok && word == 4'(g + 9)),
      .ctl_we(wr_ok && word == 4'(g + 1)),
      .wdata(bus_wdata), .in_lvl(ch_in[g]),
      .val(ch_val[g]), .flag(ch_flag[g]), .sync(ch_sync[g]), .hit(ch_hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      div_q  <= 2'd0;
      mode_q <= MODE_STOP;
      ovf_q  <= 1'b0;
    end else begin
      if (ctl_wr) begin
        src_q  <= bus_wdata[0];
        div_q  <= bus_wdata[2:1];
        mode_q <= mode_e'(bus_wdata[4:3]);
      end
      ovf_q <= (ctl_wr ? bus_wdata[6] : ovf_q) | ovf_set;
    end
  end

  always_comb begin
    rd_val = '0;
    if (word == W_CTL) rd_val = {9'd0, ovf_q, 1'b0, mode_q, div_q, src_q};
    if (word == W_CNT) rd_val = cnt_q;
    for (int i = 0; i < NCH; i++) begin
      if (word == 4'(i + 1)) rd_val = {14'd0, ch_sync[i], ch_flag[i]};
      if (word == 4'(i + 9)) rd_val = ch_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_ok ? rd_val : '0;
      bus_err   <= bus_en && !legal;
    end
  end

  assign ovf_flag = ovf_q;
  assign cmp_flag = ch_flag;

  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));
  assert_ovf_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag);
  assert_bad_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr[0] && !ovf_set) |=> $stable(ovf_flag));
endmodule

// File: tb/tb_tmr_core.sv
`timescale 1ns/100ps
module tb_tmr_core;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic bus_err;
  logic tick_a = 0, tick_b = 0;
  logic [NCH-1:0] ch_in = '0;
  logic ovf_flag;
  logic [NCH-1:0] cmp_flag;

  always #2.5 clk = ~clk;

  tmr_core #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .tick_a(tick_a), .tick_b(tick_b), .ch_in(ch_in),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_pre, m_div, m_src, m_mode, m_dir, m_ovf;
  int m_val [NCH];
  bit m_flag [NCH];
  bit m_sync [NCH];
  int e_rdata;
  bit e_err;

  always @(posedge clk) begin : model
    int w, per, nc, nd;
    bit ok, wrc, wcnt, clrv, tk, stp, run, adv, ov;
    bit hitv [NCH];
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_div = 0; m_src = 0; m_mode = 0; m_dir = 0; m_ovf = 0;
      for (int i = 0; i < NCH; i++) begin m_val[i] = 0; m_flag[i] = 0; m_sync[i] = 0; end
      e_rdata = 0; e_err = 0;
    end else begin
      w  = int'(bus_addr) / 2;
      ok = bus_en && !bus_addr[0] &&
           (w == 0 || w == 8 || (w >= 1 && w <= NCH) || (w >= 9 && w <= 8 + NCH));
      e_err = bus_en && !ok;
      e_rdata = 0;
      if (ok && !bus_wr) begin
        if (w == 0) e_rdata = m_src + 2 * m_div + 8 * m_mode + 64 * m_ovf;
        else if (w == 8) e_rdata = m_cnt;
        else if (w < 8) e_rdata = int'(m_flag[w-1]) + 2 * int'(m_sync[w-1]);
        else e_rdata = m_val[w-9];
      end
      wrc  = ok && bus_wr && w == 0;
      wcnt = ok && bus_wr && w == 8;
      clrv = wrc && bus_wdata[5];
      tk   = (m_src != 0) ? tick_b : tick_a;
      stp  = 0;
      if (clrv || (wrc && int'(bus_wdata[2:1]) != m_div)) m_pre = 0;
      else if (tk) begin
        if (m_pre + 1 == (1 << m_div)) begin stp = 1; m_pre = 0; end
        else m_pre++;
      end
      per = m_val[0];
      run = (m_mode != 0) && !(m_mode != 2 && per == 0);
      adv = stp && run && !wcnt && !clrv;
      ov = 0; nc = m_cnt; nd = m_dir;
      for (int i = 0; i < NCH; i++) hitv[i] = adv && (m_cnt == m_val[i]);
      if (adv) begin
        if (m_mode == 1) begin
          if (m_cnt >= per) begin nc = 0; ov = 1; end else nc = m_cnt + 1;
        end else if (m_mode == 2) begin
          nc = (m_cnt + 1) % 65536; ov = (m_cnt == 65535);
        end else begin
          if (m_dir == 0 && m_cnt < per) nc = m_cnt + 1;
          else if (m_dir == 1 && m_cnt == 0) begin nc = 1; nd = 0; end
          else begin nc = m_cnt - 1; ov = (nc == 0); nd = (nc == 0) ? 0 : 1; end
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (ok && bus_wr && w == i + 1) m_flag[i] = bus_wdata[0];
        if (ok && bus_wr && w == i + 9) m_val[i] = int'(bus_wdata);
        if (hitv[i]) begin m_flag[i] = 1; m_sync[i] = ch_in[i]; end
      end
      if (wrc) begin
        m_src = int'(bus_wdata[0]); m_div = int'(bus_wdata[2:1]);
        m_mode = int'(bus_wdata[4:3]); m_ovf = int'(bus_wdata[6]);
      end
      if (ov) m_ovf = 1;
      if (clrv) begin m_cnt = 0; m_dir = 0; end
      else if (wcnt) m_cnt = int'(bus_wdata);
      else if (adv) begin m_cnt = nc; m_dir = nd; end
    end
  end

  // per-cycle comparison, half a cycle after each edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(ovf_flag) == m_ovf, "R6 model ovf", int'(ovf_flag), m_ovf);
      for (int i = 0; i < NCH; i++)
        chk(cmp_flag[i] == m_flag[i], "R10 model flag", int'(cmp_flag[i]), int'(m_flag[i]));
      chk(bus_err == e_err, "R11 model err", int'(bus_err), int'(e_err));
      chk(int'(bus_rdata) == e_rdata, "R11 model rdata", int'(bus_rdata), e_rdata);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input int expd, input bit experr, input string tag);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    chk(int'(bus_rdata) == expd, tag, int'(bus_rdata), expd);
    chk(bus_err == experr, tag, int'(bus_err), int'(experr));
  endtask

  task automatic tk(input bit use_b, input int n);
    for (int k = 0; k < n; k++) begin
      if (use_b) tick_b = 1; else tick_a = 1;
      @(negedge clk);
    end
    tick_a = 0; tick_b = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, 0, 0, "R1 ctl");
    rd(5'h10, 0, 0, "R1 cnt");
    rd(5'h02, 0, 0, "R1 chctl0");
    rd(5'h14, 0, 0, "R1 chval1");
    chk(ovf_flag == 0 && cmp_flag == 0, "R1 flags", int'(cmp_flag), 0);

    // R11 address map and errors
    rd(5'h01, 0, 1, "R11 odd");
    rd(5'h08, 0, 1, "R11 missing chctl");
    wr(5'h13, 16'h1234);
    rd(5'h12, 0, 0, "R11 odd write ignored");
    wr(5'h18, 16'h0055);
    rd(5'h18, 0, 1, "R11 missing chval");
    wr(5'h16, 16'h0077);
    rd(5'h16, 16'h0077, 0, "R11 chval2");

    // R3 / R4 source and divide
    wr(5'h00, 16'h0030); tk(0, 80); rd(5'h10, 80, 0, "R4 div1");
    tk(1, 100); rd(5'h10, 80, 0, "R3 other source");
    wr(5'h00, 16'h0032); rd(5'h10, 0, 0, "R5 clear");
    tk(0, 80); rd(5'h10, 40, 0, "R4 div2");
    wr(5'h00, 16'h0034); tk(0, 80); rd(5'h10, 20, 0, "R4 div4");
    wr(5'h00, 16'h0036); tk(0, 80); rd(5'h10, 10, 0, "R4 div8");
    wr(5'h00, 16'h0031); tk(1, 80); rd(5'h10, 80, 0, "R3 source b");
    tk(0, 50); rd(5'h10, 80, 0, "R3 source a ignored");

    // R13 prescaler restart on divide change
    wr(5'h00, 16'h0036); tk(0, 5); rd(5'h10, 0, 0, "R13 partial");
    wr(5'h00, 16'h0014); tk(0, 4); rd(5'h10, 1, 0, "R13 restart");

    // R2 stop mode
    wr(5'h12, 16'd100);
    wr(5'h00, 16'h0020); tk(0, 10); rd(5'h10, 0, 0, "R2 stop");
    wr(5'h10, 16'd7); tk(0, 10); rd(5'h10, 7, 0, "R2 stop loaded");

    // R7 zero period
    wr(5'h12, 16'd0);
    wr(5'h00, 16'h0028); tk(0, 10); rd(5'h10, 0, 0, "R7 up hold");
    wr(5'h00, 16'h0038); tk(0, 10); rd(5'h10, 0, 0, "R7 updown hold");
    wr(5'h00, 16'h0030); tk(0, 10); rd(5'h10, 10, 0, "R7 continuous runs");

    // R6 up mode wrap
    wr(5'h12, 16'd10);
    wr(5'h00, 16'h0028);
    wr(5'h02, 16'h0000);
    tk(0, 10); rd(5'h10, 10, 0, "R6 at top");
    chk(ovf_flag == 0, "R6 no early ovf", int'(ovf_flag), 0);
    tk(0, 1); rd(5'h10, 0, 0, "R6 wrapped");
    chk(ovf_flag == 1, "R6 ovf", int'(ovf_flag), 1);
    chk(cmp_flag[0] == 1, "R6 ch0 flag", int'(cmp_flag[0]), 1);
    rd(5'h00, 16'h0048, 0, "R6 ctl readback");
    wr(5'h02, 16'h0000); wr(5'h00, 16'h0008);
    rd(5'h02, 0, 0, "R12 flag cleared");
    rd(5'h00, 16'h0008, 0, "R12 ovf cleared");

    // R8 continuous wrap, R12 load
    wr(5'h00, 16'h0030); wr(5'h10, 16'hFFFE);
    rd(5'h10, 16'hFFFE, 0, "R12 load");
    tk(0, 1); rd(5'h10, 16'hFFFF, 0, "R8 top");
    chk(ovf_flag == 0, "R8 no early ovf", int'(ovf_flag), 0);
    tk(0, 1); rd(5'h10, 0, 0, "R8 wrap");
    chk(ovf_flag == 1, "R8 ovf", int'(ovf_flag), 1);

    // R9 up/down
    wr(5'h12, 16'd4); wr(5'h00, 16'h0038);
    tk(0, 4); rd(5'h10, 4, 0, "R9 top");
    tk(0, 1); rd(5'h10, 3, 0, "R9 descend");
    tk(0, 2); rd(5'h10, 1, 0, "R9 near floor");
    chk(ovf_flag == 0, "R9 no early ovf", int'(ovf_flag), 0);
    tk(0, 1); rd(5'h10, 0, 0, "R9 floor");
    chk(ovf_flag == 1, "R9 ovf", int'(ovf_flag), 1);
    tk(0, 1); rd(5'h10, 1, 0, "R9 climbs again");

    // R10 compare flag and sampled input
    wr(5'h00, 16'h0030); wr(5'h14, 16'd5); ch_in = 3'b010; wr(5'h04, 16'h0000);
    tk(0, 5); rd(5'h04, 0, 0, "R10 before match");
    tk(0, 1); rd(5'h04, 3, 0, "R10 match high");
    ch_in = 3'b000; wr(5'h04, 16'h0000); wr(5'h10, 16'd5);
    tk(0, 1); rd(5'h04, 1, 0, "R10 match low");

    // R5 clear mid-count
    tk(0, 3); wr(5'h00, 16'h0030);
    rd(5'h10, 0, 0, "R5 clear count");
    rd(5'h00, 16'h0010, 0, "R5 clear bit reads 0");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule